// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It watches the instruction that has just moved into execute. If that instruction is a load, and the instruction now in decode names the load's target register as one of its two source operands, the loaded value cannot arrive in time. The block then holds the program counter and the fetch/decode pipeline register for one cycle. In the same cycle it turns the instruction that enters execute into a bubble.

The block owns the control half of the decode/execute pipeline register: the execute, memory and writeback control fields, plus the target register index of the instruction entering execute. A bubble is made by writing all-zero control fields into that register. The bubble therefore carries no ALU selection and causes no register or memory write as it moves downstream. The instruction in decode is held and decoded again in the next cycle. By then the load has moved on to the memory stage, so the conflict clears and the pipeline resumes. Forwarding paths, memories and the data half of the pipeline register belong to other blocks.

Top module: `load_use_stall_unit`

## Requirements
- R1: `bubble` is 1 in the same cycle when the registered memory-read bit (`idex_mem_ctrl[0]`) is 1, `idex_rt` is non-zero and `idex_rt` equals `dec_rs`.
- R2: `bubble` is 1 in the same cycle when `idex_mem_ctrl[0]` is 1, `idex_rt` is non-zero and `idex_rt` equals `dec_rt`.
- R3: While `idex_mem_ctrl[0]` is 0, `bubble` stays 0 whatever the register indices are. A store (`idex_mem_ctrl[1]`) or a branch (`idex_mem_ctrl[2]`) in execute never stalls.
- R4: A load whose target `idex_rt` is register 0 never raises `bubble`, even when both decode sources are also 0.
- R5: `pc_wr_en` and `ifid_wr_en` are each the inverse of `bubble`. Both are 0 during a stall and 1 otherwise.
- R6: On the clock edge that ends a stall cycle, `idex_ex_ctrl`, `idex_mem_ctrl` and `idex_wb_ctrl` are all loaded with zero.
- R7: On the clock edge of a cycle without a stall, `idex_ex_ctrl`, `idex_mem_ctrl` and `idex_wb_ctrl` take the values of `dec_ex_ctrl`, `dec_mem_ctrl` and `dec_wb_ctrl`. On every edge outside reset, stall or not, `idex_rt` takes `dec_rt`.
- R8: A stall lasts one cycle. If the decode inputs are held steady, `bubble` is 0 in the cycle after a stall cycle.
- R9: With `rst` high at a clock edge, the three control outputs and `idex_rt` are cleared to zero. In the following cycle `bubble` is 0 and both write enables are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs | input | 5 | First source register index of the instruction in decode |
| dec_rt | input | 5 | Second source/target register index of the instruction in decode |
| dec_ex_ctrl | input | 4 | Decoded execute controls {alu_op[1:0], alu_src, reg_dst} |
| dec_mem_ctrl | input | 3 | Decoded memory controls {branch, write, read} |
| dec_wb_ctrl | input | 2 | Decoded writeback controls {mem_to_reg, reg_write} |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | Fetch/decode pipeline register write enable |
| bubble | output | 1 | Stall indication; zeroes the control fields entering execute |
| idex_ex_ctrl | output | 4 | Registered execute controls of the instruction in execute |
| idex_mem_ctrl | output | 3 | Registered memory controls; bit 0 marks a load |
| idex_wb_ctrl | output | 2 | Registered writeback controls |
| idex_rt | output | 5 | Registered target register index of the instruction in execute |

## Verification
`bubble`, `pc_wr_en` and `ifid_wr_en` are combinational and are due in the same cycle as the decode inputs that cause them. The registered control fields and `idex_rt` are due one clock edge after the cycle whose inputs they capture. The bench therefore drives new decode inputs just after a falling edge and checks the stall outputs a short delay later, before the next rising edge. It checks the registered outputs at that same point, against a model that it advances at each rising edge from the stall value it expects rather than the stall value the design produces. The one-cycle stall and the resume after it are checked by repeating the same decode inputs on two consecutive vectors.

// File: rtl/lu_pkg.sv
package lu_pkg;

    localparam int REG_AW    = 5;
    localparam int ALU_OP_W  = 2;
    localparam int NUM_SRC   = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef struct packed {
        logic [ALU_OP_W-1:0] alu_op;
        logic                alu_src;
        logic                reg_dst;
    } ex_ctrl_t;

    typedef struct packed {
        logic branch;
        logic write;
        logic read;
    } mem_ctrl_t;

    typedef struct packed {
        logic mem_to_reg;
        logic reg_write;
    } wb_ctrl_t;

    typedef struct packed {
        ex_ctrl_t  ex;
        mem_ctrl_t mem;
        wb_ctrl_t  wb;
    } stage_ctrl_t;

    localparam int EX_W    = $bits(ex_ctrl_t);
    localparam int MEM_W   = $bits(mem_ctrl_t);
    localparam int WB_W    = $bits(wb_ctrl_t);
    localparam int CTRL_W  = $bits(stage_ctrl_t);
    localparam int SRC_BUS = NUM_SRC * REG_AW;

    // A register index names a real producer only when it is not the hardwired zero register.
    function automatic logic idx_conflict(reg_idx_t producer, reg_idx_t consumer);
        return (producer != '0) && (producer == consumer);
    endfunction

endpackage

// File: rtl/lu_src_compare.sv
module lu_src_compare
    import lu_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [N_SRC*REG_AW-1:0] src_idx,
    input  reg_idx_t                tgt_idx,
    input  logic                    tgt_is_load,
    output logic                    hit
);
    logic [N_SRC-1:0] per_src;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            assign per_src[g] = idx_conflict(tgt_idx, src_idx[g*REG_AW +: REG_AW]);
        end
    endgenerate

    assign hit = tgt_is_load && (|per_src);

endmodule

// File: rtl/lu_idex_ctrl_reg.sv
module lu_idex_ctrl_reg
    import lu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        kill,
    input  stage_ctrl_t ctrl_d,
    input  reg_idx_t    rt_d,
    output stage_ctrl_t ctrl_q,
    output reg_idx_t    rt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rt_q   <= '0;
        end else begin
            ctrl_q <= kill ? stage_ctrl_t'('0) : ctrl_d;
            rt_q   <= rt_d;
        end
    end

    assert_bubble_zeroes_R6: assert property (@(posedge clk) disable iff (rst)
        kill |=> (ctrl_q == '0));

    assert_ctrl_passes_R7: assert property (@(posedge clk) disable iff (rst)
        !kill |=> (ctrl_q == $past(ctrl_d)));

    assert_rt_passes_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rt_q == $past(rt_d)));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && rt_q == '0));

endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit
    import lu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [REG_AW-1:0]  dec_rs,
    input  logic [REG_AW-1:0]  dec_rt,
    input  logic [EX_W-1:0]    dec_ex_ctrl,
    input  logic [MEM_W-1:0]   dec_mem_ctrl,
    input  logic [WB_W-1:0]    dec_wb_ctrl,
    output logic               pc_wr_en,
    output logic               ifid_wr_en,
    output logic               bubble,
    output logic [EX_W-1:0]    idex_ex_ctrl,
    output logic [MEM_W-1:0]   idex_mem_ctrl,
    output logic [WB_W-1:0]    idex_wb_ctrl,
    output logic [REG_AW-1:0]  idex_rt
);
    stage_ctrl_t dec_ctrl;
    stage_ctrl_t ex_ctrl_q;
    reg_idx_t    ex_rt_q;
    logic        stall;

    assign dec_ctrl = '{ex: ex_ctrl_t'(dec_ex_ctrl),
                        mem: mem_ctrl_t'(dec_mem_ctrl),
                        wb: wb_ctrl_t'(dec_wb_ctrl)};

    lu_src_compare #(.N_SRC(NUM_SRC)) u_cmp (
        .src_idx     ({dec_rt, dec_rs}),
        .tgt_idx     (ex_rt_q),
        .tgt_is_load (ex_ctrl_q.mem.read),
        .hit         (stall)
    );

    lu_idex_ctrl_reg u_idex (
        .clk    (clk),
        .rst    (rst),
        .kill   (stall),
        .ctrl_d (dec_ctrl),
        .rt_d   (dec_rt),
        .ctrl_q (ex_ctrl_q),
        .rt_q   (ex_rt_q)
    );

    assign bubble        = stall;
    assign pc_wr_en      = !stall;
    assign ifid_wr_en    = !stall;
    assign idex_ex_ctrl  = ex_ctrl_q.ex;
    assign idex_mem_ctrl = ex_ctrl_q.mem;
    assign idex_wb_ctrl  = ex_ctrl_q.wb;
    assign idex_rt       = ex_rt_q;

    assert_rs_conflict_R1: assert property (@(posedge clk) disable iff (rst)
        (idex_mem_ctrl[0] && idex_rt != '0 && idex_rt == dec_rs) |-> bubble);

    assert_rt_conflict_R2: assert property (@(posedge clk) disable iff (rst)
        (idex_mem_ctrl[0] && idex_rt != '0 && idex_rt == dec_rt) |-> bubble);

    assert_non_load_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !idex_mem_ctrl[0] |-> !bubble);

    assert_zero_target_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (idex_rt == '0) |-> !bubble);

    assert_hold_fetch_R5: assert property (@(posedge clk) disable iff (rst)
        bubble |-> (!pc_wr_en && !ifid_wr_en));

    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        bubble |=> !bubble);

endmodule

// File: tb/load_use_stall_unit_bench.sv
module load_use_stall_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // fields: rs[19:15] rt[14:10] mem{branch,write,read}[9:7] wb[6:5] ex[4:1] expected_stall[0]
    localparam logic [19:0] VEC [NVEC] = '{
        {5'd1,  5'd2,  3'b001, 2'b11, 4'h0, 1'b0},
        {5'd2,  5'd3,  3'b000, 2'b01, 4'h3, 1'b1},
        {5'd2,  5'd3,  3'b000, 2'b01, 4'h3, 1'b0},
        {5'd4,  5'd5,  3'b001, 2'b11, 4'h2, 1'b0},
        {5'd6,  5'd5,  3'b000, 2'b01, 4'hA, 1'b1},
        {5'd6,  5'd5,  3'b000, 2'b01, 4'hA, 1'b0},
        {5'd1,  5'd0,  3'b001, 2'b11, 4'h2, 1'b0},
        {5'd0,  5'd0,  3'b000, 2'b01, 4'h5, 1'b0},
        {5'd7,  5'd8,  3'b010, 2'b00, 4'h2, 1'b0},
        {5'd8,  5'd8,  3'b000, 2'b01, 4'hC, 1'b0},
        {5'd3,  5'd9,  3'b001, 2'b11, 4'h2, 1'b0},
        {5'd9,  5'd10, 3'b001, 2'b11, 4'h2, 1'b1},
        {5'd9,  5'd10, 3'b001, 2'b11, 4'h2, 1'b0},
        {5'd10, 5'd10, 3'b100, 2'b00, 4'h4, 1'b1},
        {5'd10, 5'd10, 3'b100, 2'b00, 4'h4, 1'b0},
        {5'd1,  5'd31, 3'b001, 2'b11, 4'h2, 1'b0},
        {5'd30, 5'd29, 3'b000, 2'b01, 4'hF, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] dec_rs = '0;
    logic [4:0] dec_rt = '0;
    logic [3:0] dec_ex_ctrl = '0;
    logic [2:0] dec_mem_ctrl = '0;
    logic [1:0] dec_wb_ctrl = '0;
    logic       pc_wr_en, ifid_wr_en, bubble;
    logic [3:0] idex_ex_ctrl;
    logic [2:0] idex_mem_ctrl;
    logic [1:0] idex_wb_ctrl;
    logic [4:0] idex_rt;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    load_use_stall_unit u_load_use_stall_unit (
        .clk(clk), .rst(rst),
        .dec_rs(dec_rs), .dec_rt(dec_rt),
        .dec_ex_ctrl(dec_ex_ctrl), .dec_mem_ctrl(dec_mem_ctrl), .dec_wb_ctrl(dec_wb_ctrl),
        .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en), .bubble(bubble),
        .idex_ex_ctrl(idex_ex_ctrl), .idex_mem_ctrl(idex_mem_ctrl),
        .idex_wb_ctrl(idex_wb_ctrl), .idex_rt(idex_rt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [19:0] v);
        dec_rs       = v[19:15];
        dec_rt       = v[14:10];
        dec_mem_ctrl = v[9:7];
        dec_wb_ctrl  = v[6:5];
        dec_ex_ctrl  = v[4:1];
    endtask

    // expected registered state: {ex, mem, wb} and target index
    logic [8:0] m_ctrl;
    logic [4:0] m_rt;
    bit         m_prev_stall;

    initial begin
        // reset state
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R9 reset ctrl/rt", {idex_ex_ctrl, idex_mem_ctrl, idex_wb_ctrl, idex_rt}, 0);
        check("R9 reset enables/bubble", {pc_wr_en, ifid_wr_en, bubble}, 3'b110);
        rst = 1'b0;
        m_ctrl = '0;
        m_rt = '0;
        m_prev_stall = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic exp_stall;
            @(negedge clk);
            drive(VEC[i]);
            exp_stall = VEC[i][0];
            #1;
            check(exp_stall ? "R1/R2 stall raised" : "R3/R4/R8 no stall", bubble, exp_stall);
            check("R5 pc write enable", pc_wr_en, !exp_stall);
            check("R5 ifid write enable", ifid_wr_en, !exp_stall);
            check(m_prev_stall ? "R6 bubble zero controls" : "R7 controls captured",
                  {idex_ex_ctrl, idex_mem_ctrl, idex_wb_ctrl}, m_ctrl);
            check("R7 target captured", idex_rt, m_rt);
            @(posedge clk);
            m_ctrl = exp_stall ? 9'd0 : {VEC[i][4:1], VEC[i][9:7], VEC[i][6:5]};
            m_rt = VEC[i][14:10];
            m_prev_stall = exp_stall;
        end

        // final registered state after the last vector
        @(negedge clk);
        #1;
        check("R7 last capture", {idex_ex_ctrl, idex_mem_ctrl, idex_wb_ctrl, idex_rt}, {m_ctrl, m_rt});

        // directed: reset taken while a load-use conflict is pending
        drive({5'd3, 5'd4, 3'b001, 2'b11, 4'h2, 1'b0});
        @(negedge clk);
        drive({5'd4, 5'd6, 3'b000, 2'b01, 4'h1, 1'b0});
        #1;
        check("R1 conflict before reset", bubble, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        #1;
        rst = 1'b0;
        check("R9 reset clears ctrl/rt", {idex_ex_ctrl, idex_mem_ctrl, idex_wb_ctrl, idex_rt}, 0);
        check("R9 no stall after reset", {pc_wr_en, ifid_wr_en, bubble}, 3'b110);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule